// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block refills one cache line after a miss. A line holds eight 64-bit words, 64 bytes in all. The refill starts at the word the processor stalled on. The controller asks memory for the line and gives the index of that word. Memory returns the words in wrap-around order. That first word goes straight to the processor in the cycle it arrives, so the stall ends after one word rather than after the whole line.

All returning words, the first one included, are stored in a line buffer at their own offsets. The processor is already running while the rest of the line arrives. During the refill the processor may ask for another word of the same line. It gets that word from the buffer if the word is already there, in the same cycle as the word's beat if the word is arriving then, and otherwise the request waits. A request to any other line is held off until the line is complete. Tag handling and multiple outstanding misses belong to the surrounding cache.

Addresses on the request port are word addresses. The low three bits select the word within the line, and the upper bits form the line address.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: After reset, `mem_req_valid`, `cpu_rsp_valid` and `line_done` are low, and the controller is idle.
- R2: While idle, a request is taken in the same cycle (`req_ready` high). One cycle later `mem_req_valid` pulses for exactly one cycle. In that cycle `mem_req_line` carries `req_addr[ADDR_W-1:3]` and `mem_req_word` carries `req_addr[2:0]`.
- R3: The first beat returned after a memory request is forwarded on `cpu_rsp_valid`/`cpu_rsp_data` in the same cycle it arrives. Later beats are not forwarded on their own.
- R4: Beat k of a refill holds word (start + k) mod 8 and is stored at that offset, so a later read of word w returns the data delivered for word w.
- R5: `line_done` is high for exactly one cycle, the cycle after the eighth beat of the refill.
- R6: From acceptance until the `line_done` cycle, a request to a different line has `req_ready` low. A request to a different line is taken in the `line_done` cycle.
- R7: During a refill, a request for a word of the same line that has already arrived is answered in the same cycle, with `req_ready` high, from the buffer.
- R8: A same-line request for a word that has not yet arrived keeps `req_ready` low. It is answered in the cycle that word's beat arrives, with the beat's data.
- R9: In the cycle of the first beat, a same-line request is not answered (`req_ready` low), because the response port is carrying the stalled word.
- R10: Beats (`mem_rvalid`) that arrive while the controller is idle are ignored. They produce no response and no `line_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request (miss or follow-up) |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Request taken or answered this cycle |
| mem_req_valid | output | 1 | One-cycle refill request to memory |
| mem_req_line | output | ADDR_W-3 | Line address of the refill |
| mem_req_word | output | 3 | Word memory must send first |
| mem_rvalid | input | 1 | Returning beat valid |
| mem_rdata | input | WORD_W | Returning beat data |
| cpu_rsp_valid | output | 1 | Data response to the processor |
| cpu_rsp_data | output | WORD_W | Response data |
| line_done | output | 1 | One-cycle pulse when the line is complete |

## Verification
Several properties are checked on every cycle:
- the one-cycle memory request that follows each acceptance;
- the same-cycle forward of the first beat;
- the `line_done` pulse that follows the last beat;
- the blocking of other lines and of responses while idle.

Only the bench's scenarios can show the rest. That covers the wrap-around placement of data, which is visible only when a later read returns the right word. It also covers how long a follow-up request waits for its word, and handing the port to a new miss in the very cycle the line completes.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_state_e;

  // Offset of the beat-th word returned when the refill starts at 'first'.
  function automatic int wrap_slot(int first, int beat, int words);
    return (first + beat) % words;
  endfunction

endpackage

// File: rtl/cwf_seq.sv
module cwf_seq #(
  parameter int WORDS  = 8,
  parameter int LINE_W = 29
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [LINE_W-1:0]         start_line,
  input  logic [$clog2(WORDS)-1:0]  start_word,
  input  logic                      mem_rvalid,
  output logic                      busy,
  output logic [LINE_W-1:0]         cur_line,
  output logic [$clog2(WORDS)-1:0]  first_word,
  output logic [$clog2(WORDS)-1:0]  wr_idx,
  output logic                      ev_beat,
  output logic                      ev_first,
  output logic                      ev_last,
  output logic                      req_pulse,
  output logic                      done_pulse
);
  import cwf_pkg::*;

  localparam int OFS_W = $clog2(WORDS);
  localparam int CNT_W = OFS_W + 1;

  fill_state_e         state_q;
  logic [OFS_W-1:0]    crit_q;
  logic [LINE_W-1:0]   line_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                req_q;
  logic                done_q;

  assign busy       = (state_q == ST_FILL);
  assign cur_line   = line_q;
  assign first_word = crit_q;
  assign ev_beat    = busy && mem_rvalid;
  assign ev_first   = ev_beat && (cnt_q == '0);
  assign ev_last    = ev_beat && (cnt_q == CNT_W'(WORDS - 1));
  assign wr_idx     = OFS_W'(wrap_slot(int'(crit_q), int'(cnt_q), WORDS));
  assign req_pulse  = req_q;
  assign done_pulse = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      crit_q  <= '0;
      line_q  <= '0;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      req_q  <= start;
      done_q <= ev_last;
      if (start) begin
        state_q <= ST_FILL;
        crit_q  <= start_word;
        line_q  <= start_line;
        cnt_q   <= '0;
      end else if (ev_beat) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (ev_last) state_q <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/cwf_linebuf.sv
module cwf_linebuf #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      we,
  input  logic [$clog2(WORDS)-1:0]  widx,
  input  logic [WORD_W-1:0]         wdata,
  input  logic [$clog2(WORDS)-1:0]  ridx,
  output logic [WORD_W-1:0]         rdata,
  output logic                      rvld
);
  localparam int OFS_W = $clog2(WORDS);

  logic [WORDS-1:0]  vld_vec;
  logic [WORD_W-1:0] data_arr [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    logic              slot_v;
    logic [WORD_W-1:0] slot_d;
    logic              slot_we;

    assign slot_we = we && (widx == OFS_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_v <= 1'b0;
      else if (clr)     slot_v <= 1'b0;
      else if (slot_we) slot_v <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (slot_we) slot_d <= wdata;
    end

    assign vld_vec[g]  = slot_v;
    assign data_arr[g] = slot_d;
  end

  assign rdata = data_arr[ridx];
  assign rvld  = vld_vec[ridx];

endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 64,
  parameter int WORDS  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic [ADDR_W-1:0]               req_addr,
  output logic                            req_ready,
  output logic                            mem_req_valid,
  output logic [ADDR_W-$clog2(WORDS)-1:0] mem_req_line,
  output logic [$clog2(WORDS)-1:0]        mem_req_word,
  input  logic                            mem_rvalid,
  input  logic [WORD_W-1:0]               mem_rdata,
  output logic                            cpu_rsp_valid,
  output logic [WORD_W-1:0]               cpu_rsp_data,
  output logic                            line_done
);
  localparam int OFS_W  = $clog2(WORDS);
  localparam int LINE_W = ADDR_W - OFS_W;

  function automatic logic [LINE_W-1:0] line_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] word_of(logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  // Named internal events, also used by the bound checker.
  logic              busy;
  logic [LINE_W-1:0] cur_line;
  logic [OFS_W-1:0]  first_word;
  logic [OFS_W-1:0]  wr_idx;
  logic              ev_beat;
  logic              ev_first;
  logic              ev_last;
  logic              ev_accept;
  logic              same_line;
  logic              beat_match;
  logic              serve_fu;
  logic [OFS_W-1:0]  fu_word;
  logic [WORD_W-1:0] buf_rdata;
  logic              buf_rvld;

  assign ev_accept  = req_valid && !busy;
  assign same_line  = busy && (line_of(req_addr) == cur_line);
  assign fu_word    = word_of(req_addr);
  assign beat_match = ev_beat && (wr_idx == fu_word);
  assign serve_fu   = req_valid && same_line && !ev_first && (buf_rvld || beat_match);

  cwf_seq #(
    .WORDS (WORDS),
    .LINE_W(LINE_W)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ev_accept),
    .start_line(line_of(req_addr)),
    .start_word(word_of(req_addr)),
    .mem_rvalid(mem_rvalid),
    .busy      (busy),
    .cur_line  (cur_line),
    .first_word(first_word),
    .wr_idx    (wr_idx),
    .ev_beat   (ev_beat),
    .ev_first  (ev_first),
    .ev_last   (ev_last),
    .req_pulse (mem_req_valid),
    .done_pulse(line_done)
  );

  cwf_linebuf #(
    .WORDS (WORDS),
    .WORD_W(WORD_W)
  ) i_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ev_accept),
    .we   (ev_beat),
    .widx (wr_idx),
    .wdata(mem_rdata),
    .ridx (fu_word),
    .rdata(buf_rdata),
    .rvld (buf_rvld)
  );

  assign req_ready     = ev_accept || serve_fu;
  assign cpu_rsp_valid = ev_first || serve_fu;
  assign cpu_rsp_data  = (ev_first || !buf_rvld) ? mem_rdata : buf_rdata;
  assign mem_req_line  = cur_line;
  assign mem_req_word  = first_word;

endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic [WORD_W-1:0] mem_rdata,
  input logic              cpu_rsp_valid,
  input logic [WORD_W-1:0] cpu_rsp_data,
  input logic              line_done,
  input logic              busy,
  input logic              same_line,
  input logic              ev_accept,
  input logic              ev_first,
  input logic              ev_last
);

  a_r2_req_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> mem_req_valid);

  a_r2_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  a_r3_first_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |-> (cpu_rsp_valid && cpu_rsp_data == mem_rdata));

  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> (line_done && !busy));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  a_r6_other_line_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && !same_line) |-> !req_ready);

  a_r9_first_beat_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |-> !req_ready);

  a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cpu_rsp_valid);

endmodule

bind cwf_refill_ctrl cwf_refill_chk #(.WORD_W(WORD_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_req_valid(mem_req_valid),
  .mem_rdata    (mem_rdata),
  .cpu_rsp_valid(cpu_rsp_valid),
  .cpu_rsp_data (cpu_rsp_data),
  .line_done    (line_done),
  .busy         (busy),
  .same_line    (same_line),
  .ev_accept    (ev_accept),
  .ev_first     (ev_first),
  .ev_last      (ev_last)
);

// File: tb/test_cwf_refill_ctrl.sv
module test_cwf_refill_ctrl;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 64;
  localparam int WORDS  = 8;
  localparam int LINE_W = ADDR_W - 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_ready;
  logic              mem_req_valid;
  logic [LINE_W-1:0] mem_req_line;
  logic [2:0]        mem_req_word;
  logic              mem_rvalid;
  logic [WORD_W-1:0] mem_rdata;
  logic              cpu_rsp_valid;
  logic [WORD_W-1:0] cpu_rsp_data;
  logic              line_done;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;
  logic [WORD_W-1:0] expq[$];

  always #2 clk = ~clk;

  cwf_refill_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) i_cwf_refill_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .mem_req_word(mem_req_word), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data), .line_done(line_done)
  );

  function automatic logic [WORD_W-1:0] pat(int line, int w);
    return 64'hA5C3_0000_0000_0000 ^ (64'(line) << 16) ^ 64'(w * 37 + 1);
  endfunction

  function automatic logic [ADDR_W-1:0] waddr(int line, int w);
    return (32'(line) << 3) | 32'(w);
  endfunction

  task automatic check(bit ok, string req, string what, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(bit rv, logic [ADDR_W-1:0] ra, bit mv, logic [WORD_W-1:0] md);
    req_valid  = rv;
    req_addr   = ra;
    mem_rvalid = mv;
    mem_rdata  = md;
  endtask

  task automatic adv();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: every processor response must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && cpu_rsp_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R3/R10", "unexpected response", cpu_rsp_data, '0);
      end else begin
        logic [WORD_W-1:0] e;
        e = expq.pop_front();
        check(cpu_rsp_data == e, "R3/R4/R7/R8", "response data", cpu_rsp_data, e);
      end
    end
  end

  initial begin
    #(4 * 20000);
    check(1'b0, "WDOG", "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(0, '0, 0, '0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req_valid && !cpu_rsp_valid && !line_done, "R1", "outputs after reset",
          {mem_req_valid, cpu_rsp_valid, line_done}, '0);
    adv();

    // Scenario A: line 100, stalled word 5.
    drive(1, waddr(100, 5), 0, '0);
    @(negedge clk);
    check(req_ready, "R2", "miss accepted when idle", req_ready, 1);
    check(!mem_req_valid, "R2", "no memory request in accept cycle", mem_req_valid, 0);
    adv();
    drive(0, '0, 0, '0);
    @(negedge clk);
    check(mem_req_valid, "R2", "memory request pulse", mem_req_valid, 1);
    check(mem_req_line == LINE_W'(100), "R2", "request line", mem_req_line, 100);
    check(mem_req_word == 3'd5, "R2", "request start word", mem_req_word, 5);
    adv();
    @(negedge clk);
    check(!mem_req_valid, "R2", "memory request single cycle", mem_req_valid, 0);
    adv();
    // first beat (word 5) with a same-line request for word 6
    drive(1, waddr(100, 6), 1, pat(100, 5));
    expq.push_back(pat(100, 5));
    @(negedge clk);
    check(cpu_rsp_valid, "R3", "critical word forwarded", cpu_rsp_valid, 1);
    check(!req_ready, "R9", "follow-up held in first-beat cycle", req_ready, 0);
    adv();
    drive(1, waddr(100, 6), 0, '0);
    @(negedge clk);
    check(!req_ready, "R8", "follow-up waits for word 6", req_ready, 0);
    adv();
    drive(1, waddr(100, 6), 1, pat(100, 6));
    expq.push_back(pat(100, 6));
    @(negedge clk);
    check(req_ready, "R8", "follow-up served on arrival", req_ready, 1);
    adv();
    drive(0, '0, 1, pat(100, 7));
    @(negedge clk);
    check(!cpu_rsp_valid, "R3", "later beat not forwarded", cpu_rsp_valid, 0);
    adv();
    drive(1, waddr(100, 5), 0, '0);
    expq.push_back(pat(100, 5));
    @(negedge clk);
    check(req_ready, "R7", "arrived word served from buffer", req_ready, 1);
    adv();
    drive(1, waddr(200, 1), 0, '0);
    @(negedge clk);
    check(!req_ready, "R6", "other line held during refill", req_ready, 0);
    adv();
    for (int k = 3; k < 8; k++) begin
      drive(1, waddr(200, 1), 1, pat(100, (5 + k) % 8));
      @(negedge clk);
      check(!req_ready, "R6", "other line held during beats", req_ready, 0);
      check(!line_done, "R5", "no completion before last beat", line_done, 0);
      adv();
    end
    // line_done cycle: other line taken now (Scenario B, start word 1)
    drive(1, waddr(200, 1), 0, '0);
    @(negedge clk);
    check(line_done, "R5", "line complete after eighth beat", line_done, 1);
    check(req_ready, "R6", "other line taken in completion cycle", req_ready, 1);
    adv();
    drive(0, '0, 0, '0);
    @(negedge clk);
    check(!line_done, "R5", "completion is one cycle", line_done, 0);
    check(mem_req_valid && mem_req_word == 3'd1 && mem_req_line == LINE_W'(200), "R2",
          "second request fields", {mem_req_valid, mem_req_word}, {1'b1, 3'd1});
    adv();
    for (int k = 0; k < 8; k++) begin
      drive(k == 5, waddr(200, 3), 1, pat(200, (1 + k) % 8));
      if (k == 0) expq.push_back(pat(200, 1));
      if (k == 5) expq.push_back(pat(200, 3));
      @(negedge clk);
      if (k == 5) check(req_ready, "R4", "wrapped word 3 read during beat", req_ready, 1);
      adv();
    end
    drive(0, '0, 0, '0);
    @(negedge clk);
    check(line_done, "R5", "back-to-back beats complete", line_done, 1);
    adv();

    // Scenario C: stray beats while idle, then a refill starting at word 7.
    for (int k = 0; k < 3; k++) begin
      drive(0, '0, 1, pat(999, k));
      @(negedge clk);
      check(!cpu_rsp_valid && !line_done && !mem_req_valid, "R10", "idle beat ignored",
            {cpu_rsp_valid, line_done, mem_req_valid}, '0);
      adv();
    end
    drive(1, waddr(300, 7), 0, '0);
    @(negedge clk);
    check(req_ready, "R2", "third miss accepted", req_ready, 1);
    adv();
    drive(0, '0, 0, '0);
    @(negedge clk);
    check(mem_req_word == 3'd7, "R2", "third start word", mem_req_word, 7);
    adv();
    for (int k = 0; k < 8; k++) begin
      drive(k >= 1, waddr(300, 6), 1, pat(300, (7 + k) % 8));
      if (k == 0) expq.push_back(pat(300, 7));
      if (k == 7) expq.push_back(pat(300, 6));
      @(negedge clk);
      if (k >= 1 && k < 7) check(!req_ready, "R8", "word 6 not yet arrived", req_ready, 0);
      if (k == 7) check(req_ready, "R8", "word 6 served on last beat", req_ready, 1);
      adv();
    end
    drive(0, '0, 0, '0);
    @(negedge clk);
    check(line_done, "R5", "wrapped refill complete", line_done, 1);
    adv();
    @(negedge clk);
    check(expq.size() == 0, "R3", "all expected responses seen", 64'(expq.size()), 0);
    finish_run();
  end

endmodule